// File: doc/BRIEF.md
# Instruction Prefetch Queue With Status

The block sits between a bus sequencer and an instruction decoder. It stores up to six instruction bytes in arrival order. It asks the sequencer for a 16-bit word whenever room for a whole word exists, and it hands bytes to the decoder one at a time. Each fetch has two phases: the address is accepted with a grant, and the data word returns on a later clock. Only one fetch is outstanding at any time. Memory is read in aligned words, and the block itself picks out the bytes.

When the queue is empty, a byte that arrives from the bus is offered to the decoder in the same clock. A taken branch empties the queue and discards any word still in flight. Fetching then restarts at the branch target. The fetch address is a 16-bit offset added to a 16-bit code segment base that is shifted left by four bits, which gives a 20-bit address. A registered 2-bit code reports, one clock later, what the queue did. External logic can use this code to follow the instruction stream.

Top module: `prefetch_queue`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty, `dec_valid` is 0 and `qstat` is 00.
- R2: Bytes reach the decoder in ascending byte address order. The first byte is the branch target, and each following byte is at the next address after the previous one. Within a returned word, the low data byte `[7:0]` is the even address and `[15:8]` is the odd address.
- R3: The queue never holds more than six bytes. After an even target with no bytes taken, exactly three words are fetched and six bytes become available.
- R4: `fetch_req` is raised only when no fetch is outstanding, at least two byte slots are free, and `flush` is low. `fetch_addr` is always even and equals `seg_base*16` plus the current fetch offset. The fetch offset advances by 2 on every grant.
- R5: While the queue is empty, a word that arrives with `fetch_rvalid` makes `dec_valid` 1 in that same clock, and `dec_byte` holds its first useful byte.
- R6: When a byte is taken, `qstat` becomes 01 if `dec_first` was 1 and 11 if it was 0.
- R7: A flush sets `qstat` to 10 and takes priority over a take in the same clock. During the flush clock `dec_valid` is 0.
- R8: `qstat` reports each clock's operation in the clock that follows it.
- R9: A flush discards every stored byte, and also the data of a fetch that was granted before the flush.
- R10: When the target is odd, only the upper byte of the first returned word is kept. Fetching continues at the next even address, so an odd target with no bytes taken fills the queue to five bytes after three words.
- R11: At most one byte leaves per clock. A take while `dec_valid` is 0 has no effect, and `qstat` is 00 for that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_base | input | 16 | Code segment base, shifted left by four bits to form the address |
| flush | input | 1 | Taken branch: empty the queue and restart fetching |
| flush_target | input | 16 | Branch target offset, used when `flush` is 1 |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | 20 | Even physical address of the requested word |
| fetch_gnt | input | 1 | Sequencer accepts the request in this clock |
| fetch_rvalid | input | 1 | Data word of the outstanding fetch is present |
| fetch_rdata | input | 16 | Returned word; bits [7:0] hold the even byte |
| dec_take | input | 1 | Decoder takes the offered byte |
| dec_first | input | 1 | The taken byte is the first byte of an opcode |
| dec_valid | output | 1 | A byte is offered to the decoder |
| dec_byte | output | 8 | Offered byte |
| qstat | output | 2 | Status of the previous clock: 00 none, 01 first byte, 10 emptied, 11 following byte |

## Verification
The hardest case to reach from the ports is a flush that lands while a granted word is still on its way back. The stale word then arrives after the new target has been set, and it must not enter the queue. The stimulus grants a fetch and flushes on the very next clock, before the bus model returns the data. It also mixes random flush timing with random return latency, so that flushes fall on every phase of a fetch. Every delivered byte is compared with a value computed from its address, so a stale or misaligned byte cannot go unnoticed. Directed fills from even and odd targets with the decoder stalled check the six-byte and five-byte limits. Repeated flushes followed by immediate takes reach the empty-queue bypass.

// File: rtl/pfq_pkg.sv
// Shared definitions of the prefetch queue.
// Assumes: nothing beyond IEEE 1800-2017.
package pfq_pkg;
    // Queue activity code, reported one clock after the operation.
    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_EMPTY = 2'b10,
        QS_NEXT  = 2'b11
    } qs_code_t;
endpackage

// File: rtl/pfq_ring.sv
// Circular byte store. Each clock it takes in up to two bytes and gives out one.
// Assumes: the caller never writes more bytes than are free, and reads only
// when the store is not empty. clr empties the store at once.
module pfq_ring #(
    parameter int DEPTH = 6,
    parameter int BW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic [1:0]                   wr_n,
    input  logic [BW-1:0]                wr_d0,
    input  logic [BW-1:0]                wr_d1,
    input  logic                         rd,
    output logic [BW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int PW = $clog2(DEPTH);
    localparam int OW = $clog2(DEPTH+1);

    logic [PW-1:0] wp, rp, wp1;
    logic [BW-1:0] slot [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign wp1  = bump(wp);
    assign head = slot[rp];

    // One register per slot, written by the first or the second incoming byte.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_n != 2'd0 && wp == PW'(i))
                slot[i] <= wr_d0;
            else if (wr_n == 2'd2 && wp1 == PW'(i))
                slot[i] <= wr_d1;
        end
    end

    // Keep the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            case (wr_n)
                2'd1:    wp <= wp1;
                2'd2:    wp <= bump(wp1);
                default: wp <= wp;
            endcase
            if (rd)
                rp <= bump(rp);
            occ <= occ + OW'(wr_n) - OW'(rd);
        end
    end
endmodule

// File: rtl/pfq_fetch.sv
// Fetch address generator. It allows one outstanding word fetch at a time.
// It keeps the even fetch offset, remembers when a granted fetch was
// overtaken by a flush (so that its data is dropped), and marks an odd
// target, so that the first word keeps only its upper byte.
// Assumes: data returns no earlier than the clock after its grant.
module pfq_fetch #(
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [15:0] target,
    input  logic [15:0] seg_base,
    input  logic        space_ok,
    input  logic        gnt,
    input  logic        rvalid,
    output logic        req,
    output logic [19:0] addr,
    output logic        word_ok,
    output logic        upper_only
);
    logic [15:0] off;
    logic        busy, drop, odd;

    assign req        = !busy && space_ok && !flush;
    assign addr       = {seg_base, 4'b0000} + {4'b0000, off};
    assign word_ok    = rvalid && !drop && !flush;
    assign upper_only = odd;

    // Follow the offset, the outstanding fetch and the drop and odd marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off  <= {RESET_OFF[15:1], 1'b0};
            busy <= 1'b0;
            drop <= 1'b0;
            odd  <= RESET_OFF[0];
        end else if (flush) begin
            off  <= {target[15:1], 1'b0};
            odd  <= target[0];
            drop <= busy && !rvalid;
            busy <= busy && !rvalid;
        end else begin
            if (req && gnt) begin
                off  <= off + 16'd2;
                busy <= 1'b1;
            end else if (rvalid) begin
                busy <= 1'b0;
            end
            if (rvalid) begin
                drop <= 1'b0;
                if (!drop)
                    odd <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pfq_status.sv
// Registered queue activity code.
// Assumes: flush outranks a take in the same clock.
module pfq_status
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       took,
    input  logic       first,
    output logic [1:0] qstat
);
    qs_code_t nxt;

    // Pick the code for this clock's operation.
    always_comb begin
        if (flush)
            nxt = QS_EMPTY;
        else if (took)
            nxt = first ? QS_FIRST : QS_NEXT;
        else
            nxt = QS_NONE;
    end

    // Report it during the following clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            qstat <= QS_NONE;
        else
            qstat <= nxt;
    end
endmodule

// File: rtl/prefetch_queue.sv
// Instruction prefetch queue. It fetches aligned words, stores up to DEPTH
// bytes and gives the decoder one byte per clock. When the queue is empty,
// the first useful incoming byte goes straight to the decoder.
// Assumes: seg_base changes only together with flush.
module prefetch_queue #(
    parameter int          DEPTH     = 6,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] seg_base,
    input  logic        flush,
    input  logic [15:0] flush_target,
    output logic        fetch_req,
    output logic [19:0] fetch_addr,
    input  logic        fetch_gnt,
    input  logic        fetch_rvalid,
    input  logic [15:0] fetch_rdata,
    input  logic        dec_take,
    input  logic        dec_first,
    output logic        dec_valid,
    output logic [7:0]  dec_byte,
    output logic [1:0]  qstat
);
    localparam int OW    = $clog2(DEPTH+1);
    localparam int LIMIT = DEPTH - 2;

    logic [OW-1:0] occ;
    logic [7:0]    head, in_b0, in_b1, wd0;
    logic [1:0]    in_n, wr_n;
    logic          word_ok, upper_only, space_ok, took, bypass, rd;

    assign space_ok = (occ <= OW'(LIMIT));

    pfq_fetch #(.RESET_OFF(RESET_OFF)) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .target(flush_target),
        .seg_base(seg_base), .space_ok(space_ok), .gnt(fetch_gnt),
        .rvalid(fetch_rvalid), .req(fetch_req), .addr(fetch_addr),
        .word_ok(word_ok), .upper_only(upper_only)
    );

    // Pick the useful bytes of the incoming word.
    always_comb begin
        in_b1 = fetch_rdata[15:8];
        in_b0 = upper_only ? fetch_rdata[15:8] : fetch_rdata[7:0];
        if (!word_ok)
            in_n = 2'd0;
        else
            in_n = upper_only ? 2'd1 : 2'd2;
    end

    assign dec_valid = !flush && (occ != '0 || in_n != 2'd0);
    assign dec_byte  = (occ != '0) ? head : in_b0;
    assign took      = dec_valid && dec_take;
    assign bypass    = took && (occ == '0);

    // Route the write and read of the store around a bypass.
    always_comb begin
        if (bypass) begin
            wr_n = in_n - 2'd1;
            wd0  = in_b1;
            rd   = 1'b0;
        end else begin
            wr_n = in_n;
            wd0  = in_b0;
            rd   = took;
        end
    end

    pfq_ring #(.DEPTH(DEPTH), .BW(8)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(flush), .wr_n(wr_n),
        .wr_d0(wd0), .wr_d1(in_b1), .rd(rd), .head(head), .occ(occ)
    );

    pfq_status u_stat (
        .clk(clk), .rst_n(rst_n), .flush(flush), .took(took),
        .first(dec_first), .qstat(qstat)
    );
endmodule

// File: rtl/pfq_checker.sv
// Properties of the prefetch queue, bound to every instance of the top module.
module pfq_checker #(
    parameter int DEPTH = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       dec_take,
    input logic                       dec_first,
    input logic                       dec_valid,
    input logic                       fetch_req,
    input logic                       fetch_gnt,
    input logic [19:0]                fetch_addr,
    input logic [1:0]                 qstat,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= ($clog2(DEPTH+1))'(DEPTH));
    p_even_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !fetch_addr[0]);
    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_gnt |=> !fetch_req);
    p_first_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_take && dec_first && !flush |=> qstat == 2'b01);
    p_flush_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> qstat == 2'b10);
    p_idle_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && !(dec_valid && dec_take) |=> qstat == 2'b00);
endmodule

bind prefetch_queue pfq_checker #(.DEPTH(DEPTH)) u_pfq_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dec_take(dec_take),
    .dec_first(dec_first), .dec_valid(dec_valid), .fetch_req(fetch_req),
    .fetch_gnt(fetch_gnt), .fetch_addr(fetch_addr), .qstat(qstat), .occ(occ)
);

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg_base = 16'h1234;
    logic        flush = 1'b0;
    logic [15:0] flush_target = 16'h0;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic        fetch_gnt = 1'b0;
    logic        fetch_rvalid = 1'b0;
    logic [15:0] fetch_rdata = 16'h0;
    logic        dec_take = 1'b0;
    logic        dec_first = 1'b0;
    logic        dec_valid;
    logic [7:0]  dec_byte;
    logic [1:0]  qstat;

    prefetch_queue uut (.*);

    always #2.5 clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] pc = 16'h0;
    logic [15:0] exp_off = 16'h0;
    int          exp_qs = 0;
    bit          pend = 1'b0;
    logic [19:0] pend_addr;
    int          pend_lat = 0;
    bit          s_valid, s_rvalid, s_grant;
    int          grants = 0;

    // Content of the memory model at a byte address.
    function automatic logic [7:0] mem_b(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[19:12] ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'b0000} + {4'b0000, o};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive the inputs, sample away from the edge, update the model.
    task automatic step(input bit f, input logic [15:0] t, input logic [15:0] s,
                        input bit tk, input bit g);
        bit pend_before;
        @(negedge clk);
        flush = f;
        flush_target = t;
        if (f) seg_base = s;
        dec_take = tk;
        dec_first = 1'($urandom % 2);
        pend_before = pend;
        if (pend && pend_lat == 0) begin
            fetch_rvalid = 1'b1;
            fetch_rdata  = {mem_b(pend_addr + 20'd1), mem_b(pend_addr)};
            pend = 1'b0;
        end else begin
            fetch_rvalid = 1'b0;
        end
        s_rvalid = fetch_rvalid;
        #1;
        if (exp_qs == 1 || exp_qs == 3)
            check(qstat == 2'(exp_qs), "R6 R8 take code", qstat, exp_qs);
        else if (exp_qs == 2)
            check(qstat == 2'(exp_qs), "R7 R8 flush code", qstat, exp_qs);
        else
            check(qstat == 2'(exp_qs), "R11 R8 idle code", qstat, exp_qs);
        if (fetch_req) begin
            check(!pend_before && !f, "R4 request while busy or flushing", 1, 0);
            check(fetch_addr == phys(seg_base, exp_off), "R4 fetch address",
                  fetch_addr, phys(seg_base, exp_off));
        end
        fetch_gnt = fetch_req && g;
        s_grant = fetch_gnt;
        #0.5;
        s_valid = dec_valid;
        if (f)
            check(!dec_valid, "R7 valid during flush", dec_valid, 0);
        else if (dec_valid)
            check(dec_byte == mem_b(phys(seg_base, pc)), "R2 R9 R10 byte order",
                  dec_byte, mem_b(phys(seg_base, pc)));
        if (f) begin
            exp_qs = 2;
            pc = t;
            exp_off = {t[15:1], 1'b0};
        end else if (dec_valid && tk) begin
            exp_qs = dec_first ? 1 : 3;
            pc = pc + 16'd1;
        end else begin
            exp_qs = 0;
        end
        if (s_grant) begin
            pend = 1'b1;
            pend_addr = fetch_addr;
            pend_lat = int'($urandom % 3);
            exp_off = exp_off + 16'd2;
            grants++;
        end else if (pend && pend_lat > 0) begin
            pend_lat--;
        end
    endtask

    // Flush to a target and let the queue fill with no takes.
    task automatic fill(input logic [15:0] t, input int avail, input string req);
        step(1'b1, t, seg_base, 1'b0, 1'b0);
        grants = 0;
        for (int i = 0; i < 30; i++) step(1'b0, 16'h0, seg_base, 1'b0, 1'b1);
        check(grants == 3, {req, " word fetches while filling"}, grants, 3);
        for (int i = 0; i < avail; i++) begin
            step(1'b0, 16'h0, seg_base, 1'b1, 1'b0);
            check(s_valid, {req, " stored byte available"}, s_valid, 1);
        end
        step(1'b0, 16'h0, seg_base, 1'b1, 1'b0);
        check(!s_valid, {req, " queue empty after drain"}, s_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(!dec_valid, "R1 valid in reset", dec_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        check(qstat == 2'b00, "R1 status after reset", qstat, 0);
        check(!dec_valid, "R1 empty after reset", dec_valid, 0);

        fill(16'h0100, 6, "R3");
        // The take on the empty queue above must report no operation.
        step(1'b0, 16'h0, seg_base, 1'b0, 1'b0);
        fill(16'h0203, 5, "R10");

        // Bypass: take every clock right after a flush.
        for (int k = 0; k < 6; k++) begin
            bit seen = 1'b0;
            step(1'b1, 16'h0400 + 16'(k * 16'd37), 16'h2000 + 16'(k), 1'b1, 1'b1);
            for (int i = 0; i < 12 && !seen; i++) begin
                step(1'b0, 16'h0, seg_base, 1'b1, 1'b1);
                if (s_rvalid) begin
                    seen = 1'b1;
                    check(s_valid, "R5 bypass on arrival", s_valid, 1);
                end
            end
        end

        // Flush right after a grant, while the word is still in flight.
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 16'h0800 + 16'(k * 16'd11), seg_base, 1'b0, 1'b0);
            while (!s_grant) step(1'b0, 16'h0, seg_base, 1'b0, 1'b1);
            step(1'b1, 16'h0C00 + 16'(k * 16'd5), seg_base, 1'b0, 1'b0);
            for (int i = 0; i < 12; i++) step(1'b0, 16'h0, seg_base, 1'b1, 1'b1);
        end

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            bit f = ($urandom % 40) == 0;
            step(f, 16'($urandom), 16'($urandom), ($urandom % 10) < 7, ($urandom % 10) < 6);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule